// File: doc/BRIEF.md
# Write Leveling Edge Search Engine

This block runs the strobe delay search of write leveling for the eight byte lanes of one memory channel. Each lane owns a delay setting made of four mixed-radix fields. The engine repeatedly fires a pair of test writes, waits a programmable settle time and then captures one feedback bit per lane. Five such samples form a round, and the per-lane count of high samples decides what each lane does next. The search has two phases. In the back-off phase a lane moves its delay down until it sees no high sample at all. In the climb phase it moves up until all five samples read high. Running both phases means the result always sits on a genuine low-to-high crossing, and never on a stray high reading near the starting point.

Each phase ends when every lane has reported done, and the done mask is cleared before the climb phase starts. When both phases are complete, the engine copies each strobe result into a data delay and advances it by a fixed number of steps chosen by the clock rate code. If any lane reaches the end of its delay range in the direction it needs to move, the whole search stops with a failure status.

States: IDLE, WRITE (two cycles, test write pulse high), SETTLE, SAMPLE, EVAL, ADVANCE, DONE and FAIL. The transitions are:
- IDLE, DONE or FAIL go to WRITE on start.
- WRITE goes to SETTLE after its second cycle.
- SETTLE goes to SAMPLE when the settle count is reached.
- SAMPLE goes back to WRITE, or to EVAL after the fifth sample.
- EVAL goes to FAIL on a range error. It goes to WRITE when lanes are still pending, and also to WRITE when the back-off phase completes. It goes to ADVANCE when the climb phase completes.
- ADVANCE goes to FAIL on overflow, or to DONE after its last step.

Top module: `wl_edge_search`

## Requirements
- R1: During and after reset, busy, done, fail and wr_pulse are low, and every strobe and data setting reads zero.
- R2: A start seen in IDLE, DONE or FAIL loads every lane's strobe setting from its preset slice, and busy is high from the next cycle. A start while busy has no effect on the sequence or the results.
- R3: Each sample holds wr_pulse high for exactly two cycles. Settle then lasts settle_cyc cycles, with a value of 0 acting as 1. One capture cycle follows. After five samples comes one evaluation cycle, so a round lasts 5*(3+settle)+1 cycles.
- R4: In the back-off phase, a pending lane whose round count of high samples is non-zero steps its strobe setting down by one. A lane with a count of zero becomes done.
- R5: In the climb phase, a pending lane whose count is below five steps up by one. A lane with a count of five becomes done.
- R6: A phase ends in the evaluation cycle where all eight lanes are done. The done mask clears between the phases. Lanes that are already done hold their setting while the other lanes keep stepping.
- R7: A setting packs pi in bits [2:0] (values 0 to 6), tap in [6:3] (0 to 14), a clock field in [8:7] (0 to 3) and coarse in [10:9] (0 to 3). A step is plus or minus one on the linear index ((coarse*4+clk)*15+tap)*7+pi, with carries and borrows between fields. The index runs from 0 to 1679.
- R8: When a pending lane needs a step beyond index 0 or index 1679, the engine enters FAIL. fail then stays high until the next start.
- R9: After the climb phase, each data setting equals the lane's strobe result advanced by 39, 32 or 42 steps for rate codes 0, 1 and 2; code 3 behaves like code 0. The advance takes one cycle per step. If any data setting would pass 1679, the engine goes to FAIL instead. Data settings change only while busy.
- R10: done stays high from the end of a successful search until the next start. At most one of busy, done and fail is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search when not busy |
| rate | input | 2 | Clock rate code selecting the data advance |
| settle_cyc | input | 16 | Settle wait in cycles after each write pair |
| preset | input | 88 | Starting strobe setting, 11 bits per lane, lane 0 lowest |
| fb_hi | input | 8 | Sampled feedback bit per lane |
| wr_pulse | output | 1 | Test write request |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished successfully |
| fail | output | 1 | Search aborted on a range limit |
| dqs_set | output | 88 | Per-lane strobe delay setting |
| dq_set | output | 88 | Per-lane derived data delay setting |

## Verification
The feedback model gives each lane an edge index and a two-step band below it where only the odd samples read high. This means a design that tested for a single high sample in the climb phase would stop two steps early, and one that required a majority in the back-off phase would stop inside the band. Presets sit on both sides of the edges and across tap and clock-field borrows, so a stepper with a wrong carry ends on the wrong index. The bench also checks that a lane left stepping after its done bit was set shows up as a displaced result. Three separate cases drive a lane into the bottom of the range, the top during climbing and the top during the advance. A missing limit check would show as wrapped settings and done instead of fail. A zero settle count, a start issued mid-run and the unused rate code catch off-by-one cycle counts and wrong defaults on every clock.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_EVAL,
        ST_ADVANCE,
        ST_DONE,
        ST_FAIL
    } wl_state_t;

    typedef enum logic {
        PH_BACKOFF = 1'b0,
        PH_CLIMB   = 1'b1
    } wl_phase_t;

endpackage

// File: rtl/wl_dly_step.sv
// One-step mixed-radix delay stepper: {coarse, clk, tap, pi}, pi lowest.
// Every radix must be at least 2.
module wl_dly_step #(
    parameter int PI_N  = 7,
    parameter int TAP_N = 15,
    parameter int CLK_N = 4,
    parameter int CRS_N = 4,
    localparam int PI_W  = $clog2(PI_N),
    localparam int TAP_W = $clog2(TAP_N),
    localparam int CLK_W = $clog2(CLK_N),
    localparam int CRS_W = $clog2(CRS_N),
    localparam int SET_W = PI_W + TAP_W + CLK_W + CRS_W
) (
    input  logic [SET_W-1:0] cur,
    input  logic             dir_up,
    output logic [SET_W-1:0] nxt,
    output logic             at_lim
);

    localparam logic [PI_W-1:0]  PI_TOP  = PI_W'(PI_N - 1);
    localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(TAP_N - 1);
    localparam logic [CLK_W-1:0] CLK_TOP = CLK_W'(CLK_N - 1);
    localparam logic [CRS_W-1:0] CRS_TOP = CRS_W'(CRS_N - 1);

    logic [PI_W-1:0]  pi_c,  pi_n;
    logic [TAP_W-1:0] tap_c, tap_n;
    logic [CLK_W-1:0] ck_c,  ck_n;
    logic [CRS_W-1:0] crs_c, crs_n;

    assign {crs_c, ck_c, tap_c, pi_c} = cur;

    always_comb begin
        pi_n   = pi_c;
        tap_n  = tap_c;
        ck_n   = ck_c;
        crs_n  = crs_c;
        at_lim = 1'b0;
        if (dir_up) begin
            if (pi_c < PI_TOP) begin
                pi_n = pi_c + 1'b1;
            end else if (tap_c < TAP_TOP) begin
                pi_n  = '0;
                tap_n = tap_c + 1'b1;
            end else if (ck_c < CLK_TOP) begin
                pi_n  = '0;
                tap_n = '0;
                ck_n  = ck_c + 1'b1;
            end else if (crs_c < CRS_TOP) begin
                pi_n  = '0;
                tap_n = '0;
                ck_n  = '0;
                crs_n = crs_c + 1'b1;
            end else begin
                at_lim = 1'b1;
            end
        end else begin
            if (pi_c != '0) begin
                pi_n = pi_c - 1'b1;
            end else if (tap_c != '0) begin
                pi_n  = PI_TOP;
                tap_n = tap_c - 1'b1;
            end else if (ck_c != '0) begin
                pi_n  = PI_TOP;
                tap_n = TAP_TOP;
                ck_n  = ck_c - 1'b1;
            end else if (crs_c != '0) begin
                pi_n  = PI_TOP;
                tap_n = TAP_TOP;
                ck_n  = CLK_TOP;
                crs_n = crs_c - 1'b1;
            end else begin
                at_lim = 1'b1;
            end
        end
    end

    assign nxt = {crs_n, ck_n, tap_n, pi_n};

endmodule

// File: rtl/wl_lane.sv
// Per-lane state: high-sample counter, done flag, strobe and data settings.
module wl_lane
    import wl_pkg::*;
#(
    parameter int SAMPLES = 5,
    parameter int PI_N    = 7,
    parameter int TAP_N   = 15,
    parameter int CLK_N   = 4,
    parameter int CRS_N   = 4,
    localparam int SET_W  = $clog2(PI_N) + $clog2(TAP_N) + $clog2(CLK_N) + $clog2(CRS_N),
    localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SET_W-1:0] preset,
    input  logic             cap,
    input  logic             fb,
    input  logic             eval,
    input  wl_phase_t        phase,
    input  logic             clr_done,
    input  logic             copy,
    input  logic             adv,
    output logic [SET_W-1:0] dqs_o,
    output logic [SET_W-1:0] dq_o,
    output logic             fin_nxt,
    output logic             err_o,
    output logic             adv_err_o
);

    logic [SET_W-1:0] dqs_q, dq_q, str_nxt, dat_nxt;
    logic [CNT_W-1:0] hcnt_q;
    logic             done_q, str_lim, dat_lim, lane_fin;

    wl_dly_step #(.PI_N(PI_N), .TAP_N(TAP_N), .CLK_N(CLK_N), .CRS_N(CRS_N)) u_str (
        .cur    (dqs_q),
        .dir_up (phase == PH_CLIMB),
        .nxt    (str_nxt),
        .at_lim (str_lim)
    );

    wl_dly_step #(.PI_N(PI_N), .TAP_N(TAP_N), .CLK_N(CLK_N), .CRS_N(CRS_N)) u_dat (
        .cur    (dq_q),
        .dir_up (1'b1),
        .nxt    (dat_nxt),
        .at_lim (dat_lim)
    );

    always_comb begin
        if (phase == PH_CLIMB) lane_fin = (hcnt_q == CNT_W'(SAMPLES));
        else                   lane_fin = (hcnt_q == '0);
    end

    assign fin_nxt   = done_q | lane_fin;
    assign err_o     = !done_q && !lane_fin && str_lim;
    assign adv_err_o = dat_lim;
    assign dqs_o     = dqs_q;
    assign dq_o      = dq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dqs_q  <= '0;
            dq_q   <= '0;
            hcnt_q <= '0;
            done_q <= 1'b0;
        end else if (load) begin
            dqs_q  <= preset;
            hcnt_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (cap) hcnt_q <= hcnt_q + CNT_W'(fb);
            if (eval) begin
                hcnt_q <= '0;
                if (!done_q) begin
                    if (lane_fin)      done_q <= 1'b1;
                    else if (!str_lim) dqs_q  <= str_nxt;
                end
            end
            if (clr_done) done_q <= 1'b0;
            if (copy)                dq_q <= dqs_q;
            else if (adv && !dat_lim) dq_q <= dat_nxt;
        end
    end

endmodule

// File: rtl/wl_edge_search.sv
module wl_edge_search
    import wl_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int SAMPLES  = 5,
    parameter int PI_N     = 7,
    parameter int TAP_N    = 15,
    parameter int CLK_N    = 4,
    parameter int CRS_N    = 4,
    parameter int SETTLE_W = 16,
    parameter int ADV_R0   = 39,
    parameter int ADV_R1   = 32,
    parameter int ADV_R2   = 42,
    localparam int SET_W   = $clog2(PI_N) + $clog2(TAP_N) + $clog2(CLK_N) + $clog2(CRS_N),
    localparam int BUS_W   = LANES * SET_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          rate,
    input  logic [SETTLE_W-1:0] settle_cyc,
    input  logic [BUS_W-1:0]    preset,
    input  logic [LANES-1:0]    fb_hi,
    output logic                wr_pulse,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [BUS_W-1:0]    dqs_set,
    output logic [BUS_W-1:0]    dq_set
);

    localparam int SIDX_W  = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam int ADV_MAX = (ADV_R0 > ADV_R1) ? ((ADV_R0 > ADV_R2) ? ADV_R0 : ADV_R2)
                                               : ((ADV_R1 > ADV_R2) ? ADV_R1 : ADV_R2);
    localparam int ADV_W   = $clog2(ADV_MAX + 1);

    wl_state_t state_q, state_d;
    wl_phase_t phase_q;

    logic                wcnt_q;
    logic [SETTLE_W-1:0] scnt_q;
    logic [SIDX_W-1:0]   sidx_q;
    logic [ADV_W-1:0]    acnt_q, adv_tgt_q, adv_sel;

    logic [LANES-1:0] fin_v, err_v, adv_err_v;
    logic all_fin, any_err, any_adv_err, settle_end, last_smp, idle_like, start_ok;
    logic ld_c, cap_c, eval_c, clr_done_c, copy_c, adv_c;

    assign all_fin     = &fin_v;
    assign any_err     = |err_v;
    assign any_adv_err = |adv_err_v;
    assign settle_end  = ({1'b0, scnt_q} + (SETTLE_W + 1)'(1)) >= {1'b0, settle_cyc};
    assign last_smp    = (sidx_q == SIDX_W'(SAMPLES - 1));
    assign idle_like   = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
    assign start_ok    = start && idle_like;

    always_comb begin
        unique case (rate)
            2'd1:    adv_sel = ADV_W'(ADV_R1);
            2'd2:    adv_sel = ADV_W'(ADV_R2);
            default: adv_sel = ADV_W'(ADV_R0);
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wcnt_q) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_end) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                state_d = last_smp ? ST_EVAL : ST_WRITE;
            end
            ST_EVAL: begin
                if (any_err)                                state_d = ST_FAIL;
                else if (all_fin && phase_q == PH_CLIMB)   state_d = ST_ADVANCE;
                else                                        state_d = ST_WRITE;
            end
            ST_ADVANCE: begin
                if (any_adv_err)                            state_d = ST_FAIL;
                else if (acnt_q == adv_tgt_q - ADV_W'(1))  state_d = ST_DONE;
            end
        endcase
    end

    // Outputs and lane controls
    always_comb begin
        wr_pulse   = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        fail       = 1'b0;
        ld_c       = start_ok;
        cap_c      = 1'b0;
        eval_c     = 1'b0;
        clr_done_c = 1'b0;
        copy_c     = 1'b0;
        adv_c      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DONE:   done = 1'b1;
            ST_FAIL:   fail = 1'b1;
            ST_WRITE: begin
                busy     = 1'b1;
                wr_pulse = 1'b1;
            end
            ST_SETTLE: busy = 1'b1;
            ST_SAMPLE: begin
                busy  = 1'b1;
                cap_c = 1'b1;
            end
            ST_EVAL: begin
                busy       = 1'b1;
                eval_c     = 1'b1;
                clr_done_c = all_fin && !any_err && (phase_q == PH_BACKOFF);
                copy_c     = all_fin && !any_err && (phase_q == PH_CLIMB);
            end
            ST_ADVANCE: begin
                busy  = 1'b1;
                adv_c = !any_adv_err;
            end
        endcase
    end

    // Sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_BACKOFF;
            wcnt_q    <= 1'b0;
            scnt_q    <= '0;
            sidx_q    <= '0;
            acnt_q    <= '0;
            adv_tgt_q <= '0;
        end else if (start_ok) begin
            phase_q   <= PH_BACKOFF;
            wcnt_q    <= 1'b0;
            sidx_q    <= '0;
            adv_tgt_q <= adv_sel;
        end else begin
            unique case (state_q)
                ST_WRITE: begin
                    wcnt_q <= ~wcnt_q;
                    scnt_q <= '0;
                end
                ST_SETTLE:  scnt_q <= scnt_q + 1'b1;
                ST_SAMPLE:  sidx_q <= last_smp ? '0 : sidx_q + 1'b1;
                ST_EVAL: begin
                    acnt_q <= '0;
                    if (all_fin && !any_err) phase_q <= PH_CLIMB;
                end
                ST_ADVANCE: acnt_q <= acnt_q + 1'b1;
                ST_IDLE, ST_DONE, ST_FAIL: ;
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : gen_lane
        wl_lane #(
            .SAMPLES (SAMPLES),
            .PI_N    (PI_N),
            .TAP_N   (TAP_N),
            .CLK_N   (CLK_N),
            .CRS_N   (CRS_N)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (ld_c),
            .preset    (preset[g*SET_W +: SET_W]),
            .cap       (cap_c),
            .fb        (fb_hi[g]),
            .eval      (eval_c),
            .phase     (phase_q),
            .clr_done  (clr_done_c),
            .copy      (copy_c),
            .adv       (adv_c),
            .dqs_o     (dqs_set[g*SET_W +: SET_W]),
            .dq_o      (dq_set[g*SET_W +: SET_W]),
            .fin_nxt   (fin_v[g]),
            .err_o     (err_v[g]),
            .adv_err_o (adv_err_v[g])
        );
    end

endmodule

// File: rtl/wl_chk.sv
module wl_chk #(
    parameter int DQ_W = 88
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            wr_pulse,
    input logic            busy,
    input logic            done,
    input logic            fail,
    input logic [DQ_W-1:0] dq_set
);

    // R3
    wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_pulse) |=> wr_pulse);

    // R3
    wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && $past(wr_pulse)) |=> !wr_pulse);

    // R3
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> busy);

    // R2
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, fail}));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R9
    dq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dq_set));

endmodule

bind wl_edge_search wl_chk #(.DQ_W(LANES * SET_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr_pulse (wr_pulse),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .dq_set   (dq_set)
);

// File: tb/tb_wl_edge_search.sv
module tb_wl_edge_search;

    localparam int CLK_NS = 10;
    localparam int NL     = 8;
    localparam int SW     = 11;
    localparam int MAXPOS = 1679;
    localparam int WDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       rate = '0;
    logic [15:0]      settle_cyc = '0;
    logic [NL*SW-1:0] preset = '0;
    logic [NL-1:0]    fb_hi = '0;
    logic             wr_pulse, busy, done, fail;
    logic [NL*SW-1:0] dqs_set, dq_set;

    wl_edge_search dut (
        .clk, .rst_n, .start, .rate, .settle_cyc, .preset, .fb_hi,
        .wr_pulse, .busy, .done, .fail, .dqs_set, .dq_set
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int pcnt  = 0;
    int edge_a [NL];
    int pre_a  [NL];
    int exp_dqs[NL];
    int exp_dq [NL];
    logic [3:0] exp_q[$];
    logic [3:0] term_code;
    bit exp_ok;

    // Codes are {wr_pulse, busy, done, fail}
    localparam logic [3:0] C_WR = 4'b1100, C_BZ = 4'b0100, C_DN = 4'b0010, C_FL = 4'b0001;

    function automatic logic [SW-1:0] pos2set(int p);
        int pi, t, c, cr;
        pi = p % 7; t = (p / 7) % 15; c = (p / 105) % 4; cr = p / 420;
        return {cr[1:0], c[1:0], t[3:0], pi[2:0]};
    endfunction

    function automatic int set2pos(logic [SW-1:0] s);
        return ((int'(s[10:9]) * 4 + int'(s[8:7])) * 15 + int'(s[6:3])) * 7 + int'(s[2:0]);
    endfunction

    function automatic bit smp(int p, int e, int k);
        if (p >= e) return 1'b1;
        if (p >= e - 2 && (k % 2) == 1) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Memory feedback model: counts write pairs, answers with each lane's edge.
    initial begin : fb_model
        bit prev_wr;
        prev_wr = 1'b0;
        forever begin
            @(negedge clk);
            if (prev_wr && !wr_pulse) pcnt++;
            prev_wr = wr_pulse;
            for (int l = 0; l < NL; l++)
                fb_hi[l] = smp(set2pos(dqs_set[l*SW +: SW]), edge_a[l], (pcnt + 4) % 5);
        end
    end

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Behavioural reference: lane positions as integers, cycle codes in a queue.
    task automatic build_model(int s, int rt);
        int pos[NL];
        bit dn[NL];
        bit failed, all;
        int sw, nadv, m, cnt;
        exp_q.delete();
        failed = 0;
        sw = (s == 0) ? 1 : s;
        for (int l = 0; l < NL; l++) pos[l] = pre_a[l];
        for (int ph = 0; ph < 2 && !failed; ph++) begin
            for (int l = 0; l < NL; l++) dn[l] = 0;
            all = 0;
            while (!all && !failed) begin
                for (int k = 0; k < 5; k++) begin
                    exp_q.push_back(C_WR); exp_q.push_back(C_WR);
                    for (int j = 0; j < sw; j++) exp_q.push_back(C_BZ);
                    exp_q.push_back(C_BZ);
                end
                exp_q.push_back(C_BZ);
                for (int l = 0; l < NL; l++) begin
                    if (dn[l]) continue;
                    cnt = 0;
                    for (int k = 0; k < 5; k++) cnt += int'(smp(pos[l], edge_a[l], k));
                    if (ph == 0) begin
                        if (cnt > 0) begin
                            if (pos[l] == 0) failed = 1; else pos[l]--;
                        end else dn[l] = 1;
                    end else begin
                        if (cnt == 5) dn[l] = 1;
                        else if (pos[l] == MAXPOS) failed = 1;
                        else pos[l]++;
                    end
                end
                all = 1;
                for (int l = 0; l < NL; l++) if (!dn[l]) all = 0;
            end
        end
        if (!failed) begin
            nadv = (rt == 1) ? 32 : (rt == 2) ? 42 : 39;
            m = MAXPOS;
            for (int l = 0; l < NL; l++) if (MAXPOS - pos[l] < m) m = MAXPOS - pos[l];
            if (m < nadv) begin
                for (int j = 0; j <= m; j++) exp_q.push_back(C_BZ);
                failed = 1;
            end else begin
                for (int j = 0; j < nadv; j++) exp_q.push_back(C_BZ);
            end
            for (int l = 0; l < NL; l++) begin
                exp_dqs[l] = pos[l];
                exp_dq[l]  = pos[l] + nadv;
            end
        end
        exp_ok    = !failed;
        term_code = failed ? C_FL : C_DN;
    endtask

    task automatic run_case(string req, int s, int rt, bit poke);
        logic [3:0] got;
        for (int l = 0; l < NL; l++) preset[l*SW +: SW] = pos2set(pre_a[l]);
        settle_cyc = 16'(s);
        rate = 2'(rt);
        build_model(s, rt);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i > 0) @(negedge clk);
            if (poke && i == 7) start = 1'b1;   // R2: start while busy
            if (poke && i == 8) start = 1'b0;
            got = {wr_pulse, busy, done, fail};
            chk(got == exp_q[i], req, $sformatf("cycle %0d code", i), int'(got), int'(exp_q[i]));
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            got = {wr_pulse, busy, done, fail};
            chk(got == term_code, exp_ok ? "R10" : "R8", "terminal code", int'(got), int'(term_code));
        end
        if (exp_ok) begin
            for (int l = 0; l < NL; l++) begin
                chk(set2pos(dqs_set[l*SW +: SW]) == exp_dqs[l], "R6", $sformatf("lane %0d strobe", l),
                    set2pos(dqs_set[l*SW +: SW]), exp_dqs[l]);
                chk(dqs_set[l*SW +: SW] == pos2set(exp_dqs[l]), "R7", $sformatf("lane %0d fields", l),
                    int'(dqs_set[l*SW +: SW]), int'(pos2set(exp_dqs[l])));
                chk(set2pos(dq_set[l*SW +: SW]) == exp_dq[l], "R9", $sformatf("lane %0d data", l),
                    set2pos(dq_set[l*SW +: SW]), exp_dq[l]);
            end
        end
    endtask

    initial begin : main
        for (int l = 0; l < NL; l++) begin edge_a[l] = 300; pre_a[l] = 300; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({wr_pulse, busy, done, fail} == 4'b0000, "R1", "status in reset", int'({wr_pulse, busy, done, fail}), 0);
        chk(dqs_set == '0, "R1", "strobe in reset", int'(dqs_set[31:0]), 0);
        chk(dq_set == '0, "R1", "data in reset", int'(dq_set[31:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({wr_pulse, busy, done, fail} == 4'b0000, "R1", "status after reset", int'({wr_pulse, busy, done, fail}), 0);

        // R4 R5 R6: mixed presets above and below edges, settle 3, rate 0
        for (int l = 0; l < NL; l++) begin
            edge_a[l] = 200 + 37 * l;
            pre_a[l]  = (l % 2 == 0) ? edge_a[l] + l : edge_a[l] - 6 - l;
        end
        run_case("R4", 3, 0, 1'b0);

        // R7 R3: borrows across tap/clock fields, zero settle, start poked mid-run (R2), rate 1
        for (int l = 0; l < NL; l++) begin
            edge_a[l] = 105 + 7 * l + 2;
            pre_a[l]  = 105 + 7 * l + 1;
        end
        edge_a[7] = 420; pre_a[7] = 421;
        run_case("R3", 0, 1, 1'b1);

        // R9: rate 2, settle 1
        for (int l = 0; l < NL; l++) begin edge_a[l] = 900 + l; pre_a[l] = 905; end
        run_case("R9", 1, 2, 1'b0);

        // R9: rate code 3 behaves like code 0
        for (int l = 0; l < NL; l++) begin edge_a[l] = 50 + 3 * l; pre_a[l] = 48 + 3 * l; end
        run_case("R9", 2, 3, 1'b0);

        // R8: back-off runs into index 0
        for (int l = 0; l < NL; l++) begin edge_a[l] = 60; pre_a[l] = 62; end
        edge_a[3] = 2; pre_a[3] = 3;
        run_case("R8", 1, 0, 1'b0);

        // R8 R2: restart after fail, climb runs into the top index
        for (int l = 0; l < NL; l++) begin edge_a[l] = 1000; pre_a[l] = 999; end
        edge_a[5] = MAXPOS + 5; pre_a[5] = MAXPOS - 3;
        run_case("R8", 1, 1, 1'b0);

        // R9: advance overflow past the top index
        for (int l = 0; l < NL; l++) begin edge_a[l] = 1200; pre_a[l] = 1199; end
        edge_a[6] = MAXPOS - 5; pre_a[6] = MAXPOS - 4;
        run_case("R9", 1, 0, 1'b0);

        // R10: clean run after failure returns to done
        for (int l = 0; l < NL; l++) begin edge_a[l] = 700 - 11 * l; pre_a[l] = 700; end
        run_case("R10", 2, 2, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule